// File: doc/BRIEF.md
# Multi-Processor Message Mailbox

This block lets several processors on one chip pass 32-bit words to each other through shared hardware queues. Every queue has its own message register: a bus write pushes a word onto the tail, and a bus read pops the oldest word from the head. Each queue also has two read-only registers. One reports whether the queue is full. The other reports how many words are waiting, so a receiver can poll without disturbing the data.

Every processor is a "user". Each user owns a private event status register and a private event enable register. Each has two event bits per queue: a new-message event and a space-available event. An event sets its bit in every user's status at once. Each user then decides through its own enable bits which events drive its interrupt line. The bus is a plain single-cycle register interface. A build parameter picks one of two register layouts for the per-user registers. In the direct layout the enable register is written whole. In the split layout there are separate set and clear registers for the enable bits, so no read-modify-write is needed.

Top module: `mbox_top`

## Requirements
- R1: After reset every queue count is 0, every status and enable register reads 0, and all user interrupt lines are low.
- R2: A write to offset 0x040 + 4*m pushes a word onto queue m. A read of that offset returns the oldest word and removes it, so words come out in the order they went in.
- R3: Each queue holds 4 words. The register at 0x080 + 4*m reads 1 when queue m holds 4 words and 0 otherwise. A push to a full queue is dropped and leaves the contents unchanged.
- R4: The register at 0x0C0 + 4*m returns the number of words held in queue m. A pop from an empty queue returns 0 and leaves the count at 0.
- R5: A successful push into queue m sets bit 2*m in the status register of every user.
- R6: A pop that takes queue m from 4 words to 3 sets bit 2*m+1 in the status register of every user.
- R7: Writing a 1 to a status bit clears it and writing a 0 leaves it unchanged. A later read returns the updated value. If a set event and a clear land in the same cycle, the set wins.
- R8: The interrupt line of user u is high exactly when the bitwise AND of that user's status and enable registers is nonzero.
- R9: In the direct layout, user u has status at 0x100 + 8*u and enable at 0x104 + 8*u. A write to the enable register replaces all of its bits.
- R10: In the split layout, user u has status at 0x104 + 16*u, enable-set at 0x108 + 16*u (writing ORs bits in) and enable-clear at 0x10C + 16*u (writing a 1 clears that bit). Both of the last two read back the enable value.
- R11: Offset 0x000 reads the version number, with the major number in bits [7:4] and the minor number in bits [3:0]. The default values are 2 and 0, which read as 0x20.
- R12: Reads of offsets that hold no register return 0. Writes to read-only or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; a read of a message register pops on the clock edge |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd; 0 when bus_rd is low |
| user_irq | output | 4 | One interrupt line per user |

## Verification
The queues are tested with four patterns. A short burst followed by a full drain shows whether words keep their order. An overfilled queue shows that the fifth push is dropped. A pop from an empty queue separates a returned 0 from a stale head value. A pop from full is the only case that raises the space-available event. Status writes of all zeros and of a single 1 show that clearing touches only the written bits. The interrupt checks enable one user at a time, which shows that every user's status is set while only the enabled user's line goes high. The split-layout instance is driven with set and clear writes whose values overlap, which shows that the OR and AND-NOT updates differ from a plain overwrite.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DEF_NUM_Q   = 8;
    localparam int DEF_NUM_U   = 4;
    localparam int DEF_Q_DEPTH = 4;
    localparam int DEF_DW      = 32;
    localparam int DEF_AW      = 9;

    localparam int REV_OFS    = 'h000;
    localparam int MSG_BASE   = 'h040;
    localparam int FULL_BASE  = 'h080;
    localparam int CNT_BASE   = 'h0C0;
    localparam int LEG_BASE   = 'h100;
    localparam int LEG_STRIDE = 8;
    localparam int SPL_BASE   = 'h104;
    localparam int SPL_STRIDE = 'h10;

    localparam logic [3:0] REV_MAJOR = 4'd2;
    localparam logic [3:0] REV_MINOR = 4'd0;

    typedef enum logic {
        LAYOUT_DIRECT,
        LAYOUT_SPLIT
    } layout_e;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_REV,
        RK_MSG,
        RK_FULL,
        RK_CNT,
        RK_STAT,
        RK_EN,
        RK_EN_SET,
        RK_EN_CLR
    } reg_kind_e;

endpackage

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec
    import mbox_pkg::*;
#(
    parameter int      NUM_Q  = DEF_NUM_Q,
    parameter int      NUM_U  = DEF_NUM_U,
    parameter int      AW     = DEF_AW,
    parameter layout_e LAYOUT = LAYOUT_DIRECT,
    localparam int     QIW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int     UIW    = (NUM_U > 1) ? $clog2(NUM_U) : 1
) (
    input  logic [AW-1:0]  addr,
    output reg_kind_e      kind,
    output logic [QIW-1:0] q_idx,
    output logic [UIW-1:0] u_idx
);

    localparam int ALIGN_BITS = 2;

    always_comb begin
        int a;
        a     = int'(addr);
        kind  = RK_NONE;
        q_idx = '0;
        u_idx = '0;
        if (addr[ALIGN_BITS-1:0] == '0) begin
            if (a == REV_OFS) begin
                kind = RK_REV;
            end else if (a >= MSG_BASE && a < MSG_BASE + 4 * NUM_Q) begin
                kind  = RK_MSG;
                q_idx = QIW'((a - MSG_BASE) >> 2);
            end else if (a >= FULL_BASE && a < FULL_BASE + 4 * NUM_Q) begin
                kind  = RK_FULL;
                q_idx = QIW'((a - FULL_BASE) >> 2);
            end else if (a >= CNT_BASE && a < CNT_BASE + 4 * NUM_Q) begin
                kind  = RK_CNT;
                q_idx = QIW'((a - CNT_BASE) >> 2);
            end else if (LAYOUT == LAYOUT_DIRECT) begin
                if (a >= LEG_BASE && a < LEG_BASE + LEG_STRIDE * NUM_U) begin
                    u_idx = UIW'((a - LEG_BASE) / LEG_STRIDE);
                    case ((a - LEG_BASE) % LEG_STRIDE)
                        0:       kind = RK_STAT;
                        4:       kind = RK_EN;
                        default: kind = RK_NONE;
                    endcase
                end
            end else begin
                if (a >= SPL_BASE && a < SPL_BASE + SPL_STRIDE * NUM_U) begin
                    u_idx = UIW'((a - SPL_BASE) / SPL_STRIDE);
                    case ((a - SPL_BASE) % SPL_STRIDE)
                        0:       kind = RK_STAT;
                        4:       kind = RK_EN_SET;
                        8:       kind = RK_EN_CLR;
                        default: kind = RK_NONE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/mbox_queue.sv
module mbox_queue #(
    parameter int  DEPTH = 4,
    parameter int  DW    = 32,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          push_evt,
    output logic          nf_evt
);

    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full     = (cnt == CW'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && (cnt != '0);
    assign push_evt = do_push;
    assign nf_evt   = do_pop && full;
    assign count    = cnt;
    assign head     = (cnt == '0) ? '0 : slots[rp];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wp] <= wdata;
    end

endmodule

// File: rtl/mbox_irq_user.sv
module mbox_irq_user #(
    parameter int NEV = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NEV-1:0] set_evt,
    input  logic           st_clr_wr,
    input  logic           en_load_wr,
    input  logic           en_set_wr,
    input  logic           en_clr_wr,
    input  logic [NEV-1:0] wdata,
    output logic [NEV-1:0] status,
    output logic [NEV-1:0] enable,
    output logic           irq
);

    logic [NEV-1:0] clr_mask;

    assign clr_mask = st_clr_wr ? wdata : '0;
    assign irq      = |(status & enable);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_mask) | set_evt;
            if (en_load_wr)     enable <= wdata;
            else if (en_set_wr) enable <= enable | wdata;
            else if (en_clr_wr) enable <= enable & ~wdata;
        end
    end

endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int      NUM_Q   = DEF_NUM_Q,
    parameter int      NUM_U   = DEF_NUM_U,
    parameter int      Q_DEPTH = DEF_Q_DEPTH,
    parameter int      DW      = DEF_DW,
    parameter int      AW      = DEF_AW,
    parameter layout_e LAYOUT  = LAYOUT_DIRECT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic [NUM_U-1:0] user_irq
);

    localparam int NEV = 2 * NUM_Q;
    localparam int QIW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int UIW = (NUM_U > 1) ? $clog2(NUM_U) : 1;
    localparam int CW  = $clog2(Q_DEPTH + 1);

    reg_kind_e      kind;
    logic [QIW-1:0] q_idx;
    logic [UIW-1:0] u_idx;

    logic [DW-1:0]  q_head [NUM_Q];
    logic [CW-1:0]  q_cnt  [NUM_Q];
    logic [NUM_Q-1:0] q_full;
    logic [NEV-1:0] evt_vec;
    logic [NEV-1:0] u_stat [NUM_U];
    logic [NEV-1:0] u_en   [NUM_U];

    logic [NUM_Q*CW-1:0]  q_cnt_flat;
    logic [NUM_U*NEV-1:0] st_flat;
    logic [NUM_U*NEV-1:0] en_flat;

    mbox_addr_dec #(
        .NUM_Q(NUM_Q), .NUM_U(NUM_U), .AW(AW), .LAYOUT(LAYOUT)
    ) dec_i (
        .addr(bus_addr), .kind(kind), .q_idx(q_idx), .u_idx(u_idx)
    );

    for (genvar m = 0; m < NUM_Q; m++) begin : g_q
        logic push_m, pop_m, new_m, nf_m;
        assign push_m = bus_wr && (kind == RK_MSG) && (q_idx == QIW'(m));
        assign pop_m  = bus_rd && (kind == RK_MSG) && (q_idx == QIW'(m));

        mbox_queue #(.DEPTH(Q_DEPTH), .DW(DW)) q_i (
            .clk(clk), .rst(rst), .push(push_m), .pop(pop_m),
            .wdata(bus_wdata), .head(q_head[m]), .count(q_cnt[m]),
            .full(q_full[m]), .push_evt(new_m), .nf_evt(nf_m)
        );

        assign evt_vec[2*m]            = new_m;
        assign evt_vec[2*m+1]          = nf_m;
        assign q_cnt_flat[m*CW +: CW]  = q_cnt[m];
    end

    for (genvar u = 0; u < NUM_U; u++) begin : g_u
        logic sel_u, st_w, en_w, set_w, clr_w;
        assign sel_u = bus_wr && (u_idx == UIW'(u));
        assign st_w  = sel_u && (kind == RK_STAT);
        assign en_w  = sel_u && (kind == RK_EN);
        assign set_w = sel_u && (kind == RK_EN_SET);
        assign clr_w = sel_u && (kind == RK_EN_CLR);

        mbox_irq_user #(.NEV(NEV)) usr_i (
            .clk(clk), .rst(rst), .set_evt(evt_vec),
            .st_clr_wr(st_w), .en_load_wr(en_w), .en_set_wr(set_w),
            .en_clr_wr(clr_w), .wdata(bus_wdata[NEV-1:0]),
            .status(u_stat[u]), .enable(u_en[u]), .irq(user_irq[u])
        );

        assign st_flat[u*NEV +: NEV] = u_stat[u];
        assign en_flat[u*NEV +: NEV] = u_en[u];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (kind)
                RK_REV:    bus_rdata = DW'({REV_MAJOR, REV_MINOR});
                RK_MSG:    bus_rdata = q_head[q_idx];
                RK_FULL:   bus_rdata = DW'(q_full[q_idx]);
                RK_CNT:    bus_rdata = DW'(q_cnt[q_idx]);
                RK_STAT:   bus_rdata = DW'(u_stat[u_idx]);
                RK_EN,
                RK_EN_SET,
                RK_EN_CLR: bus_rdata = DW'(u_en[u_idx]);
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
    import mbox_pkg::*;
#(
    parameter int  NUM_Q   = DEF_NUM_Q,
    parameter int  NUM_U   = DEF_NUM_U,
    parameter int  Q_DEPTH = DEF_Q_DEPTH,
    parameter int  DW      = DEF_DW,
    parameter int  AW      = DEF_AW,
    localparam int NEV     = 2 * NUM_Q,
    localparam int CW      = $clog2(Q_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [AW-1:0]        bus_addr,
    input logic [DW-1:0]        bus_rdata,
    input logic [NUM_U-1:0]     user_irq,
    input logic [NUM_Q*CW-1:0]  q_cnt_flat,
    input logic [NUM_U*NEV-1:0] st_flat,
    input logic [NUM_U*NEV-1:0] en_flat
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> user_irq == '0); // R1

    for (genvar m = 0; m < NUM_Q; m++) begin : g_qa
        logic hit_m;
        assign hit_m = (bus_addr == AW'(MSG_BASE + 4 * m));

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            q_cnt_flat[m*CW +: CW] <= CW'(Q_DEPTH)); // R3

        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
            (q_cnt_flat[m*CW +: CW] == $past(q_cnt_flat[m*CW +: CW])) ||
            (q_cnt_flat[m*CW +: CW] == $past(q_cnt_flat[m*CW +: CW]) + 1'b1) ||
            (q_cnt_flat[m*CW +: CW] + 1'b1 == $past(q_cnt_flat[m*CW +: CW]))); // R2

        AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
            (bus_rd && hit_m && q_cnt_flat[m*CW +: CW] == '0) |-> bus_rdata == '0); // R4

        for (genvar u = 0; u < NUM_U; u++) begin : g_ua
            AST_NEWMSG_SET: assert property (@(posedge clk) disable iff (rst)
                (bus_wr && !bus_rd && hit_m && q_cnt_flat[m*CW +: CW] < CW'(Q_DEPTH))
                |=> st_flat[u*NEV + 2*m]); // R5
        end
    end

    for (genvar u = 0; u < NUM_U; u++) begin : g_ia
        AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
            user_irq[u] |-> (en_flat[u*NEV +: NEV] != '0)); // R8
    end

endmodule

bind mbox_top mbox_checker #(
    .NUM_Q(NUM_Q), .NUM_U(NUM_U), .Q_DEPTH(Q_DEPTH), .DW(DW), .AW(AW)
) chk_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .user_irq(user_irq),
    .q_cnt_flat(q_cnt_flat), .st_flat(st_flat), .en_flat(en_flat)
);

// File: tb/mbox_top_tb_top.sv
module mbox_top_tb_top;
    import mbox_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_d = 1'b0, rd_d = 1'b0, wr_s = 1'b0, rd_s = 1'b0;
    logic [8:0]  b_addr  = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata_d, rdata_s;
    logic [3:0]  irq_d, irq_s;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mbox_top #(.LAYOUT(LAYOUT_DIRECT)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(wr_d), .bus_rd(rd_d), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(rdata_d), .user_irq(irq_d)
    );

    mbox_top #(.LAYOUT(LAYOUT_SPLIT)) dut_split_i (
        .clk(clk), .rst(rst), .bus_wr(wr_s), .bus_rd(rd_s), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(rdata_s), .user_irq(irq_s)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input bit split, input int addr, input logic [31:0] data);
        @(negedge clk);
        b_addr  = 9'(addr);
        b_wdata = data;
        if (split) wr_s = 1'b1; else wr_d = 1'b1;
        @(posedge clk);
        #1;
        wr_s = 1'b0;
        wr_d = 1'b0;
    endtask

    task automatic bus_read(input bit split, input int addr, output logic [31:0] data);
        @(negedge clk);
        b_addr = 9'(addr);
        if (split) rd_s = 1'b1; else rd_d = 1'b1;
        #2;
        data = split ? rdata_s : rdata_d;
        @(posedge clk);
        #1;
        rd_s = 1'b0;
        rd_d = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq direct", 32'(irq_d), 32'h0);
        chk("R1 irq split", 32'(irq_s), 32'h0);
        bus_read(0, 'h0C0, v); chk("R1 count q0", v, 0);
        bus_read(0, 'h118, v); chk("R1 status u3", v, 0);
        bus_read(0, 'h104, v); chk("R1 enable u0", v, 0);
        bus_read(0, 'h000, v); chk("R11 version direct", v, 32'h20);
        bus_read(1, 'h000, v); chk("R11 version split", v, 32'h20);
    endtask

    task automatic t_fifo_order();
        logic [31:0] v;
        bus_write(0, 'h048, 32'hA1A1_0001);
        bus_write(0, 'h048, 32'hB2B2_0002);
        bus_write(0, 'h048, 32'hC3C3_0003);
        bus_read(0, 'h0C8, v); chk("R4 count q2 after 3 pushes", v, 3);
        bus_read(0, 'h088, v); chk("R3 q2 not full", v, 0);
        bus_read(0, 'h048, v); chk("R2 first out", v, 32'hA1A1_0001);
        bus_read(0, 'h048, v); chk("R2 second out", v, 32'hB2B2_0002);
        bus_read(0, 'h048, v); chk("R2 third out", v, 32'hC3C3_0003);
        bus_read(0, 'h0C8, v); chk("R4 q2 drained", v, 0);
    endtask

    task automatic t_overfill();
        logic [31:0] v;
        for (int i = 0; i < 5; i++) bus_write(0, 'h054, 32'h500 + 32'(i));
        bus_read(0, 'h094, v); chk("R3 q5 full flag", v, 1);
        bus_read(0, 'h0D4, v); chk("R3 q5 count capped", v, 4);
        for (int i = 0; i < 4; i++) begin
            bus_read(0, 'h054, v); chk("R3 q5 content kept", v, 32'h500 + 32'(i));
        end
        bus_read(0, 'h094, v); chk("R3 q5 full clears", v, 0);
    endtask

    task automatic t_empty_pop();
        logic [31:0] v;
        bus_read(0, 'h044, v); chk("R4 empty pop returns 0", v, 0);
        bus_read(0, 'h0C4, v); chk("R4 empty count stays 0", v, 0);
    endtask

    task automatic t_status_irq();
        logic [31:0] v;
        for (int u = 0; u < 4; u++) bus_write(0, 'h100 + 8*u, 32'hFFFF);
        bus_write(0, 'h04C, 32'h33);
        for (int u = 0; u < 4; u++) begin
            bus_read(0, 'h100 + 8*u, v); chk("R5 new-message bit 6 every user", v, 32'h40);
        end
        for (int i = 0; i < 3; i++) bus_write(0, 'h04C, 32'h34 + 32'(i));
        bus_read(0, 'h04C, v); chk("R2 q3 head", v, 32'h33);
        bus_read(0, 'h108, v); chk("R6 not-full bit 7 set", v, 32'hC0);
        bus_write(0, 'h100, 32'h0);
        bus_read(0, 'h100, v); chk("R7 write 0 no effect", v, 32'hC0);
        bus_write(0, 'h100, 32'h40);
        bus_read(0, 'h100, v); chk("R7 write 1 clears bit", v, 32'h80);
        chk("R8 no enable no irq", 32'(irq_d), 0);
        bus_write(0, 'h114, 32'h80);
        chk("R8 R9 user2 irq only", 32'(irq_d), 32'h4);
        bus_write(0, 'h114, 32'h10);
        bus_read(0, 'h114, v); chk("R9 enable replaced", v, 32'h10);
        chk("R9 irq drops after replace", 32'(irq_d), 0);
        for (int i = 0; i < 3; i++) bus_read(0, 'h04C, v);
        bus_read(0, 'h0CC, v); chk("R4 q3 drained", v, 0);
    endtask

    task automatic t_split();
        logic [31:0] v;
        bus_write(1, 'h040, 32'h77);
        bus_read(1, 'h114, v); chk("R10 R5 split status u1", v, 32'h1);
        bus_write(1, 'h118, 32'h1);
        chk("R10 R8 split irq u1", 32'(irq_s), 32'h2);
        bus_write(1, 'h118, 32'h2);
        bus_read(1, 'h118, v); chk("R10 enable-set ORs", v, 32'h3);
        bus_write(1, 'h11C, 32'h1);
        bus_read(1, 'h11C, v); chk("R10 enable-clear", v, 32'h2);
        chk("R10 irq drops after clear", 32'(irq_s), 0);
        bus_read(1, 'h100, v); chk("R12 direct offset unmapped in split", v, 0);
        bus_read(1, 'h1F0, v); chk("R12 unmapped split", v, 0);
        bus_write(0, 'h080, 32'h1);
        bus_read(0, 'h080, v); chk("R12 read-only write ignored", v, 0);
        bus_write(0, 'h1F0, 32'h1);
        bus_read(0, 'h1F0, v); chk("R12 unmapped direct", v, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fifo_order();
        t_overfill();
        t_empty_pop();
        t_status_irq();
        t_split();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule